// File: doc/BRIEF.md
# TDM Input Frame-Boundary Detector

This block locates the frame boundary of an incoming time-division-multiplexed serial bus. The external bus clock and the frame pulse are treated as asynchronous inputs. A fast system clock oversamples them through a two-stage synchronizer, and bus clock edges are found by comparing successive samples. Three configuration bits set how the boundary is recognized: the active level of the frame pulse, the positioning convention, and which bus clock edge marks the boundary. In the default convention the pulse straddles the defining edge. In the alternate convention the pulse is sampled on the opposite edge and the boundary falls on the next defining edge.

A bus clock of 4.096, 8.192 or 16.384 MHz gives 512, 1024 or 2048 clock periods per 125 us frame. A two-bit rate field selects among these frame lengths, which are scaled from a base-length parameter (a power of two, at least 8). On every accepted boundary the block emits a one-system-cycle start strobe and zeroes a position counter. That counter advances on each defining edge and is presented as a bit index (three bits) and a channel index. Two level flags report faults. One flags a frame pulse longer than one bus clock period. The other flags a frame that is missing for longer than one frame plus a tolerance. While a frame is missing the counter keeps running freely.

Top module: `tdm_frame_sync`

## Requirements
- R1: While reset is asserted and after it is released with the bus clock idle, frame_start, frame_lost and width_err are 0 and the bit and channel counts are 0.
- R2: With all configuration bits low, the pulse is active low and is sampled on each falling bus clock edge. A falling edge that samples it active, with the previous sample inactive, is a boundary.
- R3: With cfg_fp_active_high set, the frame pulse is active high and otherwise behaves as in R2, R4 and R5.
- R4: With cfg_rise_edge set, rising bus clock edges define and sample the boundary instead of falling edges.
- R5: With cfg_gci_mode set, the pulse is sampled on the edge opposite the defining edge. A first active sample makes the next defining edge a boundary. A pulse seen only on defining edges is not accepted.
- R6: The position advances by one on each defining edge that is not a boundary and wraps to 0 without a strobe after the frame length minus one. The frame length is FRAME_BASE for cfg_rate 0, 2*FRAME_BASE for 1, and 4*FRAME_BASE for 2 or 3. bit_cnt is the position modulo 8 and chan_cnt is the position divided by 8. A boundary sets the position to 0.
- R7: A frame pulse that is active on two consecutive sample edges sets width_err, and the second sample is not a boundary. width_err clears on the next accepted boundary.
- R8: frame_lost sets on the defining edge that makes FRAME_LEN+LOSS_TOL defining edges without a boundary, counted since the last boundary or since reset. It clears on the next boundary, and the position keeps running meanwhile.
- R9: A boundary accepted on the very edge that would reach the loss limit wins, and frame_lost stays 0.
- R10: frame_start is high for exactly one system clock cycle per accepted boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_clk | input | 1 | External bus clock (asynchronous) |
| tdm_fp | input | 1 | External frame pulse (asynchronous) |
| cfg_fp_active_high | input | 1 | 1: frame pulse active high; 0: active low |
| cfg_gci_mode | input | 1 | 1: sample pulse on opposite edge, boundary on next defining edge |
| cfg_rise_edge | input | 1 | 1: rising bus clock edge defines boundary; 0: falling |
| cfg_rate | input | 2 | Frame length select: 0 base, 1 double, 2/3 quadruple |
| frame_start | output | 1 | One-cycle strobe on each accepted boundary |
| bit_cnt | output | 3 | Bit index within the channel |
| chan_cnt | output | CHAN_W | Channel index within the frame |
| frame_lost | output | 1 | Frame pulse missing beyond length plus tolerance |
| width_err | output | 1 | Frame pulse longer than one bus clock period |

## Verification
Boundary acceptance and the frame-loss threshold can meet on the same defining edge. The bench provokes this from reset by sending exactly FRAME_LEN+LOSS_TOL-1 idle bus clock periods and then a pulse, so that the pulse's defining edge is the one that would trip the loss limit. The result is judged at the ports. frame_lost must stay low, exactly one start strobe must appear, and the counters must read zero. A companion case sends one more idle period instead and expects the flag to rise.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    typedef enum logic [1:0] {
        RATE_BASE  = 2'd0,
        RATE_DBL   = 2'd1,
        RATE_QUAD  = 2'd2,
        RATE_QUADX = 2'd3
    } rate_e;

    // Frame length in bus clock periods for a given base and rate code.
    function automatic int unsigned frame_len(input int unsigned base, input logic [1:0] rate);
        case (rate_e'(rate))
            RATE_BASE: return base;
            RATE_DBL:  return base * 2;
            default:   return base * 4;
        endcase
    endfunction

endpackage

// File: rtl/tfs_sync.sv
module tfs_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '0;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/tfs_edge.sv
module tfs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_s,
    input  logic bus_fp_s,
    input  logic cfg_fp_active_high,
    input  logic cfg_rise_edge,
    output logic def_evt,
    output logic opp_evt,
    output logic fp_act
);

    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d  = bus_clk_s;
        rise    = bus_clk_s & ~prev_q;
        fall    = ~bus_clk_s & prev_q;
        def_evt = cfg_rise_edge ? rise : fall;
        opp_evt = cfg_rise_edge ? fall : rise;
        fp_act  = cfg_fp_active_high ? bus_fp_s : ~bus_fp_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/tfs_track.sv
module tfs_track
    import tfs_pkg::*;
#(
    parameter int FRAME_BASE = 512,
    parameter int LOSS_TOL   = 4,
    parameter int POS_W      = 11,
    parameter int MISS_W     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             def_evt,
    input  logic             opp_evt,
    input  logic             fp_act,
    input  logic             cfg_gci_mode,
    input  logic [1:0]       cfg_rate,
    output logic             frame_start,
    output logic [POS_W-1:0] pos,
    output logic             frame_lost,
    output logic             width_err
);

    typedef struct packed {
        logic [POS_W-1:0]  pos;
        logic [MISS_W-1:0] miss;
        logic [1:0]        run;
        logic              pend;
        logic              lost;
        logic              werr;
        logic              start;
    } trk_t;

    trk_t st_d, st_q;

    logic [POS_W:0]    len;
    logic [MISS_W-1:0] limit;
    logic              sample_evt;
    logic              accept;

    always_comb begin
        len        = (POS_W+1)'(frame_len(FRAME_BASE, cfg_rate));
        limit      = MISS_W'(len) + MISS_W'(LOSS_TOL);
        sample_evt = cfg_gci_mode ? opp_evt : def_evt;

        accept = 1'b0;
        if (def_evt) begin
            accept = cfg_gci_mode ? st_q.pend : (fp_act && (st_q.run == 2'd0));
        end

        st_d       = st_q;
        st_d.start = 1'b0;

        // Pulse width tracking on sample edges
        if (sample_evt) begin
            if (fp_act) begin
                if (st_q.run != 2'd0) st_d.werr = 1'b1;
                if (st_q.run != 2'd3) st_d.run  = st_q.run + 2'd1;
            end else begin
                st_d.run = 2'd0;
            end
            if (cfg_gci_mode) st_d.pend = fp_act && (st_q.run == 2'd0);
        end

        // Position, loss and boundary on defining edges
        if (def_evt) begin
            st_d.pend = 1'b0;
            if (accept) begin
                st_d.pos   = '0;
                st_d.miss  = '0;
                st_d.lost  = 1'b0;
                st_d.werr  = 1'b0;
                st_d.start = 1'b1;
            end else begin
                if ({1'b0, st_q.pos} >= len - 1'b1) st_d.pos = '0;
                else                                 st_d.pos = st_q.pos + 1'b1;
                if (st_q.miss != limit) st_d.miss = st_q.miss + 1'b1;
                if (st_q.miss + 1'b1 >= limit) st_d.lost = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_start = st_q.start;
    assign pos         = st_q.pos;
    assign frame_lost  = st_q.lost;
    assign width_err   = st_q.werr;

endmodule

// File: rtl/tdm_frame_sync.sv
module tdm_frame_sync #(
    parameter  int FRAME_BASE  = 512,
    parameter  int LOSS_TOL    = 4,
    parameter  int SYNC_STAGES = 2,
    localparam int POS_W       = $clog2(FRAME_BASE * 4),
    localparam int CHAN_W      = POS_W - 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tdm_clk,
    input  logic              tdm_fp,
    input  logic              cfg_fp_active_high,
    input  logic              cfg_gci_mode,
    input  logic              cfg_rise_edge,
    input  logic [1:0]        cfg_rate,
    output logic              frame_start,
    output logic [2:0]        bit_cnt,
    output logic [CHAN_W-1:0] chan_cnt,
    output logic              frame_lost,
    output logic              width_err
);

    localparam int MISS_W = $clog2(FRAME_BASE * 4 + LOSS_TOL + 1);

    logic [1:0]       sync_out;
    logic             def_evt, opp_evt, fp_act;
    logic [POS_W-1:0] pos;

    tfs_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tdm_fp, tdm_clk}),
        .dout  (sync_out)
    );

    tfs_edge i_edge (
        .clk                (clk),
        .rst_n              (rst_n),
        .bus_clk_s          (sync_out[0]),
        .bus_fp_s           (sync_out[1]),
        .cfg_fp_active_high (cfg_fp_active_high),
        .cfg_rise_edge      (cfg_rise_edge),
        .def_evt            (def_evt),
        .opp_evt            (opp_evt),
        .fp_act             (fp_act)
    );

    tfs_track #(
        .FRAME_BASE (FRAME_BASE),
        .LOSS_TOL   (LOSS_TOL),
        .POS_W      (POS_W),
        .MISS_W     (MISS_W)
    ) i_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .def_evt      (def_evt),
        .opp_evt      (opp_evt),
        .fp_act       (fp_act),
        .cfg_gci_mode (cfg_gci_mode),
        .cfg_rate     (cfg_rate),
        .frame_start  (frame_start),
        .pos          (pos),
        .frame_lost   (frame_lost),
        .width_err    (width_err)
    );

    assign bit_cnt  = pos[2:0];
    assign chan_cnt = pos[POS_W-1:3];

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker #(
    parameter int CHAN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [2:0]        bit_cnt,
    input logic [CHAN_W-1:0] chan_cnt,
    input logic              frame_lost,
    input logic              width_err
);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !frame_start);

    assert_start_zero_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (bit_cnt == 3'd0 && chan_cnt == '0));

    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !$stable({chan_cnt, bit_cnt})) |->
        (({chan_cnt, bit_cnt} == $past({chan_cnt, bit_cnt}) + 1'b1) || ({chan_cnt, bit_cnt} == '0)));

    assert_start_clears_loss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !frame_lost);

    assert_start_clears_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !width_err);

    assert_loss_rises_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_lost) |-> !frame_start);

endmodule

bind tdm_frame_sync tfs_checker #(.CHAN_W(CHAN_W)) i_tfs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bit_cnt     (bit_cnt),
    .chan_cnt    (chan_cnt),
    .frame_lost  (frame_lost),
    .width_err   (width_err)
);

// File: tb/test_tdm_frame_sync.sv
module test_tdm_frame_sync;

    localparam int FB     = 16;
    localparam int TOL    = 4;
    localparam int CHAN_W = $clog2(FB * 4) - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tdm_clk = 1'b0;
    logic tdm_fp = 1'b1;
    logic cfg_fp_active_high = 1'b0;
    logic cfg_gci_mode = 1'b0;
    logic cfg_rise_edge = 1'b0;
    logic [1:0] cfg_rate = 2'd0;
    logic frame_start;
    logic [2:0] bit_cnt;
    logic [CHAN_W-1:0] chan_cnt;
    logic frame_lost;
    logic width_err;

    int n_checks = 0;
    int n_fail = 0;
    int strobes = 0;
    int run_len = 0;
    int max_run = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    tdm_frame_sync #(.FRAME_BASE(FB), .LOSS_TOL(TOL)) i_tdm_frame_sync (
        .clk                (clk),
        .rst_n              (rst_n),
        .tdm_clk            (tdm_clk),
        .tdm_fp             (tdm_fp),
        .cfg_fp_active_high (cfg_fp_active_high),
        .cfg_gci_mode       (cfg_gci_mode),
        .cfg_rise_edge      (cfg_rise_edge),
        .cfg_rate           (cfg_rate),
        .frame_start        (frame_start),
        .bit_cnt            (bit_cnt),
        .chan_cnt           (chan_cnt),
        .frame_lost         (frame_lost),
        .width_err          (width_err)
    );

    // Strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (frame_start) begin
            strobes = strobes + 1;
            run_len = run_len + 1;
            if (run_len > max_run) max_run = run_len;
        end else begin
            run_len = 0;
        end
    end

    // {pol, gci, rise, pulse_in_high_half, idle_periods[3:0], exp_strobes[1:0], exp_pos[5:0]}
    localparam int NV = 9;
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b0, 4'd3, 2'd1, 6'd3},  // R2
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd5, 2'd1, 6'd5},  // R3
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd4, 2'd1, 6'd4},  // R4
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd2, 2'd1, 6'd2},  // R3 + R4
        {1'b0, 1'b1, 1'b0, 1'b1, 4'd6, 2'd1, 6'd6},  // R5
        {1'b0, 1'b1, 1'b1, 1'b0, 4'd3, 2'd1, 6'd2},  // R5 + R4
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd7, 2'd1, 6'd6},  // R5 + R3
        {1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 2'd0, 6'd4},  // R2 pulse off the sample edge
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd3, 2'd0, 6'd4}   // R5 pulse only at defining edge
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus clock period: high half then low half, frame pulse per half
    task automatic period(input logic fp_hi, input logic fp_lo);
        tdm_clk = 1'b1; tdm_fp = fp_hi; tick(4);
        tdm_clk = 1'b0; tdm_fp = fp_lo; tick(4);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) period(~cfg_fp_active_high, ~cfg_fp_active_high);
    endtask

    task automatic pulse(input bit in_high_half);
        if (in_high_half) period(cfg_fp_active_high, ~cfg_fp_active_high);
        else              period(~cfg_fp_active_high, cfg_fp_active_high);
    endtask

    task automatic settle();
        tdm_fp = ~cfg_fp_active_high;
        tick(6);
    endtask

    task automatic do_reset(input logic pol, input logic gci, input logic rise, input logic [1:0] rate);
        rst_n = 1'b0;
        cfg_fp_active_high = pol;
        cfg_gci_mode = gci;
        cfg_rise_edge = rise;
        cfg_rate = rate;
        tdm_clk = 1'b0;
        tdm_fp = ~pol;
        tick(4);
        strobes = 0;
        rst_n = 1'b1;
        tick(2);
    endtask

    function automatic int pos_now();
        return int'(chan_cnt) * 8 + int'(bit_cnt);
    endfunction

    initial begin
        tick(2);
        // R1: reset state
        do_reset(1'b0, 1'b0, 1'b0, 2'd0);
        tick(4);
        check(frame_start == 1'b0 && frame_lost == 1'b0 && width_err == 1'b0, "R1 flags",
              int'({frame_start, frame_lost, width_err}), 0);
        check(pos_now() == 0, "R1 position", pos_now(), 0);

        // Configuration table
        for (int v = 0; v < NV; v++) begin
            logic [15:0] e;
            e = VEC[v];
            do_reset(e[15], e[14], e[13], 2'd0);
            pulse(e[12]);
            idle(int'(e[11:8]));
            settle();
            check(strobes == int'(e[7:6]), $sformatf("R2/R3/R4/R5 row %0d strobes", v),
                  strobes, int'(e[7:6]));
            check(pos_now() == int'(e[5:0]), $sformatf("R6 row %0d position", v),
                  pos_now(), int'(e[5:0]));
            check(frame_lost == 1'b0 && width_err == 1'b0, $sformatf("R7/R8 row %0d flags quiet", v),
                  int'({frame_lost, width_err}), 0);
        end

        // R6: wrap at base length without strobe
        do_reset(1'b0, 1'b0, 1'b0, 2'd0);
        pulse(1'b0); idle(16); settle();
        check(pos_now() == 0, "R6 wrap at 16", pos_now(), 0);
        check(strobes == 1, "R6 no strobe on wrap", strobes, 1);

        // R6: double length
        do_reset(1'b0, 1'b0, 1'b0, 2'd1);
        pulse(1'b0); idle(20); settle();
        check(bit_cnt == 3'd4 && chan_cnt == 2, "R6 rate 1 count", pos_now(), 20);

        // R6: quadruple length
        do_reset(1'b0, 1'b0, 1'b0, 2'd2);
        pulse(1'b0); idle(40); settle();
        check(pos_now() == 40, "R6 rate 2 count", pos_now(), 40);
        check(frame_lost == 1'b0, "R8 no loss inside long frame", int'(frame_lost), 0);

        // R7: over-long pulse
        do_reset(1'b0, 1'b0, 1'b0, 2'd0);
        pulse(1'b0); pulse(1'b0); settle();
        check(width_err == 1'b1, "R7 width error set", int'(width_err), 1);
        check(strobes == 1, "R7 second sample not a boundary", strobes, 1);
        check(pos_now() == 1, "R7 position after long pulse", pos_now(), 1);
        idle(2); pulse(1'b0); settle();
        check(width_err == 1'b0, "R7 width error cleared", int'(width_err), 0);
        check(strobes == 2, "R7 next boundary accepted", strobes, 2);

        // R8: frame loss
        do_reset(1'b0, 1'b0, 1'b0, 2'd0);
        pulse(1'b0); idle(FB + TOL - 1); settle();
        check(frame_lost == 1'b0, "R8 just below limit", int'(frame_lost), 0);
        idle(1); settle();
        check(frame_lost == 1'b1, "R8 loss at limit", int'(frame_lost), 1);
        check(pos_now() == 4, "R8 free-running position", pos_now(), 4);
        pulse(1'b0); settle();
        check(frame_lost == 1'b0, "R8 loss cleared", int'(frame_lost), 0);
        check(strobes == 2 && pos_now() == 0, "R8 boundary after loss", strobes, 2);

        // R8: loss counted from reset
        do_reset(1'b1, 1'b0, 1'b1, 2'd0);
        idle(FB + TOL); settle();
        check(frame_lost == 1'b1, "R8 loss from reset", int'(frame_lost), 1);

        // R9: boundary on the limit edge
        do_reset(1'b0, 1'b0, 1'b0, 2'd0);
        idle(FB + TOL - 1); settle();
        check(strobes == 0 && pos_now() == 3, "R6 free-run wrap from reset", pos_now(), 3);
        pulse(1'b0); settle();
        check(frame_lost == 1'b0, "R9 accept beats loss", int'(frame_lost), 0);
        check(strobes == 1 && pos_now() == 0, "R9 boundary taken", strobes, 1);

        // R10: strobe width
        check(max_run == 1, "R10 strobe one cycle", max_run, 1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks = n_checks + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule